// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes audio samples from a three-wire serial link: a bit clock, a data line and a frame sync. It turns them into parallel words in the master-clock domain. A 3-bit mode input picks the framing. In one mode the block is the link master and drives bit clock and frame sync from the master clock. In every other mode both lines arrive from outside. Each external line passes through a two-flop synchronizer. Data is taken on the rising bit-clock edge as seen after that synchronizer.

Each finished sample is loaded into an output register together with a right-channel flag. A strobe of one master-clock cycle marks the load. The next sample shifts in while that register holds the previous one. Words are left-aligned in 24 bits, and any bit the link did not carry reads as zero. Any word length from 16 to 24 bits is accepted. A short word may be padded with zeros or sent in a shorter slot.

Top module: `audio_sport_rx`

## Requirements
- R1: `sck_oe` is 1 only while `mode` is 3'b000. In every other mode `sck_out` and `fsync_out` stay at 0.
- R2: In mode 3'b000, `sck_out` toggles on every master clock, so the bit clock is the master clock divided by 2. `fsync_out` toggles once every 64 master clocks, which is 32 bit periods. It changes only while `sck_out` is low.
- R3: Modes 3'b000 and 3'b001 are left/right framing with MSB first. The first bit sampled after a frame-sync level change is the MSB. Frame sync high marks the left channel. If the slot has fewer than 24 bits, the missing LSBs are zero. If the slot has more than 24 bits, only its first 24 bits are kept.
- R4: Mode 3'b100 is like R3 except that each word starts one bit period after the frame-sync change. In this mode frame sync low marks the left channel.
- R5: In mode 3'b010, a word starts with the bit sampled when frame sync first reads high. The MSB comes first, and a word ends at the next rising edge of frame sync. The channel flag alternates, and the first reported word after reset is left.
- R6: Modes 3'b101 and 3'b110 keep only the last 16 or 18 bits, respectively, before a frame-sync change. The LSB is the last of these bits. The output is left-aligned, so its low 8 or 6 bits are zero. Channel coding is as in R3.
- R7: In mode 3'b111, bits arrive LSB first. The last bit before a frame-sync change becomes bit 23. A word shorter than 24 bits fills the top bits and leaves the low bits zero. Channel coding is as in R3.
- R8: Mode 3'b011 produces no strobe and holds `sample_data` at zero.
- R9: `sample_valid` is a one-cycle pulse for each completed word. Reset clears the frame-sync history to low. The bits received before the first frame boundary after reset are never reported.
- R10: `sample_data` and `sample_right` keep their value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Framing format select |
| sck_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| sdata_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock (master mode) |
| fsync_out | output | 1 | Generated frame sync (master mode) |
| sck_oe | output | 1 | High when the clock outputs are driven |
| sample_data | output | 24 | Left-aligned received word |
| sample_right | output | 1 | 1 when the word belongs to the right channel |
| sample_valid | output | 1 | One-cycle load strobe |

## Verification
The hardest situation to reach is the first frame boundary after reset. Here the cleared frame-sync history meets whatever level the pin already has. In the I2S-style mode this turns an idle high level into an early boundary, so the bits before it are discarded. Each stimulus vector therefore starts with a dummy slot of known level. The bench predicts the exact number of strobes per mode from that rule. The words under test are placed after the dummy slot, and a short tail slot closes the last of them.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic [2:0] {
    FMT_MASTER  = 3'b000,
    FMT_LR      = 3'b001,
    FMT_WSYNC   = 3'b010,
    FMT_RSVD    = 3'b011,
    FMT_I2S     = 3'b100,
    FMT_LSB16   = 3'b101,
    FMT_LSB18   = 3'b110,
    FMT_MSBLAST = 3'b111
  } fmt_e;
endpackage

// File: rtl/asr_clkgen.sv
module asr_clkgen #(
  parameter int unsigned HALF_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic sck_o,
  output logic fs_o,
  output logic oe_o
);
  // two master clocks per bit, HALF_BITS bits per frame-sync level
  localparam int unsigned CW = $clog2(HALF_BITS) + 2;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = enable ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sck_o = cnt_q[0];
  assign fs_o  = cnt_q[CW-1];
  assign oe_o  = enable;
endmodule

// File: rtl/asr_front.sv
module asr_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_gen,
  input  logic gen_sck,
  input  logic gen_fs,
  input  logic pin_sck,
  input  logic pin_fs,
  input  logic pin_sd,
  output logic bit_stb,
  output logic fs_lvl,
  output logic sd_lvl
);
  // bit 0: clock, bit 1: frame sync, bit 2: data
  logic [2:0] raw;
  logic [2:0] stg [STAGES];
  logic       sck_prev;

  assign raw = use_gen ? {pin_sd, gen_fs, gen_sck} : {pin_sd, pin_fs, pin_sck};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      sck_prev <= 1'b0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sck_prev <= stg[STAGES-1][0];
    end
  end

  assign bit_stb = stg[STAGES-1][0] & ~sck_prev;
  assign fs_lvl  = stg[STAGES-1][1];
  assign sd_lvl  = stg[STAGES-1][2];
endmodule

// File: rtl/asr_framer.sv
module asr_framer
  import asr_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              bit_stb,
  input  logic              fs_lvl,
  input  logic              sd_lvl,
  output logic [WORD_W-1:0] out_data,
  output logic              out_right,
  output logic              out_valid
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam int unsigned PAD16 = WORD_W - 16;
  localparam int unsigned PAD18 = WORD_W - 18;

  logic              fs_d1_q, fs_d1_d, fs_d2_q, fs_d2_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              armed_q, armed_d, ws_right_q, ws_right_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              right_q, right_d, valid_q, valid_d;

  logic              is_ws, is_i2s, is_rsvd, msb_last, lsbj;
  logic              brk, ch_right, emit;
  logic [WORD_W-1:0] word;

  always_comb begin
    is_ws    = (fmt == FMT_WSYNC);
    is_i2s   = (fmt == FMT_I2S);
    is_rsvd  = (fmt == FMT_RSVD);
    msb_last = (fmt == FMT_MSBLAST);
    lsbj     = (fmt == FMT_LSB16) || (fmt == FMT_LSB18);
    if (is_ws)       brk = fs_lvl & ~fs_d1_q;
    else if (is_i2s) brk = fs_d1_q ^ fs_d2_q;
    else             brk = fs_lvl ^ fs_d1_q;
    if (is_ws)       ch_right = ws_right_q;
    else if (is_i2s) ch_right = fs_d2_q;
    else             ch_right = ~fs_d1_q;
  end

  always_comb begin
    unique case (fmt)
      FMT_LSB16:   word = sh_q << PAD16;
      FMT_LSB18:   word = sh_q << PAD18;
      FMT_MSBLAST: word = sh_q;
      default:     word = (cnt_q >= CNT_FULL) ? sh_q : (sh_q << (CNT_FULL - cnt_q));
    endcase
  end

  always_comb begin
    fs_d1_d    = fs_d1_q;
    fs_d2_d    = fs_d2_q;
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    armed_d    = armed_q;
    ws_right_d = ws_right_q;
    if (bit_stb) begin
      fs_d1_d = fs_lvl;
      fs_d2_d = fs_d1_q;
      if (brk) begin
        sh_d    = msb_last ? {sd_lvl, {(WORD_W-1){1'b0}}} : {{(WORD_W-1){1'b0}}, sd_lvl};
        cnt_d   = CNT_W'(1);
        armed_d = 1'b1;
        if (armed_q && is_ws) ws_right_d = ~ws_right_q;
      end else begin
        if (msb_last)                     sh_d = {sd_lvl, sh_q[WORD_W-1:1]};
        else if (lsbj || cnt_q < CNT_FULL) sh_d = {sh_q[WORD_W-2:0], sd_lvl};
        if (cnt_q < CNT_FULL) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    emit    = bit_stb & brk & armed_q & ~is_rsvd;
    data_d  = data_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (is_rsvd) begin
      data_d  = '0;
      right_d = 1'b0;
    end else if (emit) begin
      data_d  = word;
      right_d = ch_right;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d1_q    <= 1'b0;
      fs_d2_q    <= 1'b0;
      sh_q       <= '0;
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      ws_right_q <= 1'b0;
      data_q     <= '0;
      right_q    <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      fs_d1_q    <= fs_d1_d;
      fs_d2_q    <= fs_d2_d;
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
      armed_q    <= armed_d;
      ws_right_q <= ws_right_d;
      data_q     <= data_d;
      right_q    <= right_d;
      valid_q    <= valid_d;
    end
  end

  assign out_data  = data_q;
  assign out_right = right_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/audio_sport_rx.sv
module audio_sport_rx
  import asr_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned HALF_BITS   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              sck_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  output logic              sck_out,
  output logic              fsync_out,
  output logic              sck_oe,
  output logic [WORD_W-1:0] sample_data,
  output logic              sample_right,
  output logic              sample_valid
);
  logic [1:0] rst_q;
  logic       rst_int_n;
  fmt_e       fmt;
  logic       is_master;
  logic       bit_stb, fs_lvl, sd_lvl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  assign fmt       = fmt_e'(mode);
  assign is_master = (fmt == FMT_MASTER);

  asr_clkgen #(.HALF_BITS(HALF_BITS)) clkgen_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .enable (is_master),
    .sck_o  (sck_out),
    .fs_o   (fsync_out),
    .oe_o   (sck_oe)
  );

  asr_front #(.STAGES(SYNC_STAGES)) front_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .use_gen (is_master),
    .gen_sck (sck_out),
    .gen_fs  (fsync_out),
    .pin_sck (sck_in),
    .pin_fs  (fsync_in),
    .pin_sd  (sdata_in),
    .bit_stb (bit_stb),
    .fs_lvl  (fs_lvl),
    .sd_lvl  (sd_lvl)
  );

  asr_framer #(.WORD_W(WORD_W)) framer_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fmt       (fmt),
    .bit_stb   (bit_stb),
    .fs_lvl    (fs_lvl),
    .sd_lvl    (sd_lvl),
    .out_data  (sample_data),
    .out_right (sample_right),
    .out_valid (sample_valid)
  );
endmodule

// File: rtl/audio_sport_rx_chk.sv
module audio_sport_rx_chk #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              sck_out,
  input logic              fsync_out,
  input logic              sck_oe,
  input logic [WORD_W-1:0] sample_data,
  input logic              sample_right,
  input logic              sample_valid
);
  // R9: strobe never lasts two cycles
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R8: reserved format stays silent and cleared
  p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b011 && $past(mode) == 3'b011) |-> (!sample_valid && sample_data == '0));

  // R1: clock pins idle outside master format
  p_pins_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b000 && $past(mode) != 3'b000) |-> (!sck_out && !fsync_out && !sck_oe));

  // R2: generated bit clock toggles each master clock
  p_sck_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 && $past(mode) == 3'b000 && $past(rst_n)) |-> (sck_out != $past(sck_out)));

  // R2: generated frame sync moves only while bit clock is low
  p_fs_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 && $past(mode) == 3'b000 && fsync_out != $past(fsync_out)) |-> !sck_out);

  // R6: unused low bits are zero in the two right-justified formats
  p_lsb16_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && mode == 3'b101 && $past(mode) == 3'b101) |-> (sample_data[WORD_W-17:0] == '0));
  p_lsb18_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && mode == 3'b110 && $past(mode) == 3'b110) |-> (sample_data[WORD_W-19:0] == '0));

  // R10: output word holds between strobes
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && $past(mode) != 3'b011) |-> ($stable(sample_data) && $stable(sample_right)));
endmodule

bind audio_sport_rx audio_sport_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .mode         (mode),
  .sck_out      (sck_out),
  .fsync_out    (fsync_out),
  .sck_oe       (sck_oe),
  .sample_data  (sample_data),
  .sample_right (sample_right),
  .sample_valid (sample_valid)
);

// File: tb/audio_sport_rx_tb_top.sv
module audio_sport_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        sck_in, fsync_in, sdata_in;
  logic        sck_out, fsync_out, sck_oe;
  logic [23:0] sample_data;
  logic        sample_right, sample_valid;

  int total = 0;
  int bad = 0;
  int npulse = 0;
  bit done = 1'b0;
  logic [23:0] cap_d [64];
  logic        cap_r [64];
  logic        fsb [256];
  logic        db  [256];
  int          slen;

  bit          mdrv = 1'b0;
  logic        mlast;
  int          midx;
  localparam logic [23:0] M_LEFT  = 24'hC0FFEE;
  localparam logic [23:0] M_RIGHT = 24'h1DEA55;

  // {mode, slot bits, left-position word, right-position word}
  localparam int NV = 13;
  localparam logic [56:0] VEC [NV] = '{
    {3'b001, 6'd24, 24'hA5C3F1, 24'h3C5A96},
    {3'b001, 6'd16, 24'hABCD55, 24'h13579B},
    {3'b001, 6'd32, 24'h0F1E2D, 24'hF0E1D2},
    {3'b100, 6'd24, 24'h8C4A21, 24'h71B3E5},
    {3'b100, 6'd20, 24'hFEDCBA, 24'h123456},
    {3'b010, 6'd24, 24'h6A5D3C, 24'h95A2C3},
    {3'b010, 6'd18, 24'hC3C3C3, 24'h5A5A5A},
    {3'b101, 6'd24, 24'h9ABC12, 24'h345678},
    {3'b101, 6'd16, 24'hE1D2C3, 24'h0A0B0C},
    {3'b110, 6'd20, 24'h9ABCDE, 24'h13579F},
    {3'b111, 6'd24, 24'h2468AC, 24'hDB9753},
    {3'b111, 6'd16, 24'h7E8F90, 24'h81706F},
    {3'b111, 6'd28, 24'h55AA33, 24'hCC3355}
  };

  always #5 clk = ~clk;

  audio_sport_rx dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .sck_in(sck_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
    .sck_out(sck_out), .fsync_out(fsync_out), .sck_oe(sck_oe),
    .sample_data(sample_data), .sample_right(sample_right), .sample_valid(sample_valid)
  );

  always @(negedge clk) begin
    if (sample_valid) begin
      if (npulse < 64) begin
        cap_d[npulse] = sample_data;
        cap_r[npulse] = sample_right;
      end
      npulse = npulse + 1;
    end
  end

  // data source for master format: next bit presented while sck_out is low
  always @(negedge clk) begin
    if (mdrv && !sck_out) begin
      if (fsync_out != mlast) begin
        midx  = 0;
        mlast = fsync_out;
      end
      sdata_in = (midx < 24) ? (fsync_out ? M_LEFT[23-midx] : M_RIGHT[23-midx]) : 1'b0;
      midx = midx + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic bit_of(input logic [2:0] m, input int n, input logic [23:0] w, input int i);
    int k, len, pad;
    case (m)
      3'b101: begin k = i - (n - 16); return (k >= 0) ? w[23-k] : 1'b0; end
      3'b110: begin k = i - (n - 18); return (k >= 0) ? w[23-k] : 1'b0; end
      3'b111: begin
        len = (n < 24) ? n : 24;
        pad = n - len;
        return (i < pad) ? 1'b0 : w[24-len+i-pad];
      end
      default: return (i < 24) ? w[23-i] : 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] expw(input logic [2:0] m, input int n, input logic [23:0] w);
    if (m == 3'b101) return {w[23:8], 8'h00};
    if (m == 3'b110) return {w[23:6], 6'h00};
    if (n >= 24) return w;
    return w & (24'hFFFFFF << (24 - n));
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'b100: return "R4";
      3'b010: return "R5";
      3'b101, 3'b110: return "R6";
      3'b111: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic add_slot(input logic [2:0] m, input int n, input logic lvl, input logic [23:0] w);
    for (int i = 0; i < n; i++) begin
      fsb[slen] = (m == 3'b010) ? (i == 0) : lvl;
      db[slen]  = bit_of(m, n, w, i);
      slen++;
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic fs0);
    rst_n = 1'b0; mode = m; sck_in = 1'b0; fsync_in = fs0; sdata_in = 1'b0; mdrv = 1'b0;
    repeat (4) @(negedge clk);
    npulse = 0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic play();
    for (int j = 0; j < slen; j++) begin
      @(negedge clk);
      sck_in = 1'b0; fsync_in = fsb[j]; sdata_in = db[j];
      repeat (4) @(negedge clk);
      sck_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    sck_in = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic build(input logic [2:0] m, input int n, input logic [23:0] wx, input logic [23:0] wy);
    bit i2s;
    i2s  = (m == 3'b100);
    slen = 0;
    add_slot(m, n, i2s, 24'h5A0F96);
    add_slot(m, n, !i2s, wx);
    add_slot(m, n, i2s, wy);
    add_slot(m, 4, !i2s, 24'h000000);
    if (i2s) begin
      for (int j = slen - 1; j > 0; j--) db[j] = db[j-1];
      db[0] = 1'b0;
    end
  endtask

  task automatic run_vec(input logic [56:0] v);
    logic [2:0]  m;
    int          n;
    logic [23:0] wx, wy;
    bit          odd_start;
    m  = v[56:54]; n = int'(v[53:48]); wx = v[47:24]; wy = v[23:0];
    odd_start = (m == 3'b100) || (m == 3'b010);
    build(m, n, wx, wy);
    do_reset(m, fsb[0]);
    play();
    // R9: words before the first boundary are dropped
    check("R9", npulse, odd_start ? 3 : 2);
    if (npulse >= 2 && npulse <= 64) begin
      check(req_of(m), cap_d[npulse-2], expw(m, n, wx));
      check(req_of(m), cap_r[npulse-2], (m == 3'b010) ? 1 : 0);
      check(req_of(m), cap_d[npulse-1], expw(m, n, wy));
      check(req_of(m), cap_r[npulse-1], (m == 3'b010) ? 0 : 1);
    end
    // R10: last word still presented after the link goes idle
    check("R10", sample_data, expw(m, n, wy));
  endtask

  initial begin
    int cnt;
    logic a;
    int np0;
    // reset state (R9, R1)
    rst_n = 1'b0; mode = 3'b001; sck_in = 0; fsync_in = 0; sdata_in = 0;
    repeat (3) @(negedge clk);
    check("R9", sample_valid, 0);
    check("R10", sample_data, 0);
    do_reset(3'b001, 1'b0);
    repeat (10) @(negedge clk);
    check("R1", {sck_out, fsync_out, sck_oe}, 3'b000);

    for (int v = 0; v < NV; v++) run_vec(VEC[v]);

    // R8: reserved format clears output and ignores a full stream
    run_vec(VEC[0]);
    mode = 3'b011;
    repeat (3) @(negedge clk);
    check("R8", sample_data, 0);
    np0 = npulse;
    play();
    check("R8", npulse, np0);
    check("R8", sample_data, 0);

    // R1, R2: master format clock generation
    do_reset(3'b000, 1'b0);
    check("R1", sck_oe, 1);
    a = sck_out;
    @(negedge clk);
    check("R2", sck_out, !a);
    a = fsync_out;
    while (fsync_out == a) @(negedge clk);
    a = fsync_out; cnt = 0;
    while (fsync_out == a) begin @(negedge clk); cnt++; end
    check("R2", cnt, 64);

    // R3: master format data capture
    do_reset(3'b000, 1'b0);
    mlast = 1'b0; midx = 0; mdrv = 1'b1;
    repeat (420) @(negedge clk);
    mdrv = 1'b0;
    check("R3", npulse >= 3, 1);
    for (int p = 0; p < npulse && p < 64; p++)
      check("R3", cap_d[p], cap_r[p] ? M_RIGHT : M_LEFT);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule